// File: doc/BRIEF.md
# Serial Voltage Command Receiver

This block listens on a two-wire, clock-and-data bus where a host processor is the only master. It decodes one write-only transaction (start, a 7-bit address plus a write bit, a data byte, stop) and uses it to set the voltage codes of two supply rails: a core rail and an auxiliary rail. The block drives the data line only in the two acknowledge slots, through an open-drain enable.

The address carries a fixed three-bit prefix and two rail-select bits. The data byte carries a 7-bit voltage code and an active-low flag that permits a power-saving state. Decoded values are held back until the stop condition. On the stop they are loaded into the addressed rails, and each loaded rail emits a one-cycle update pulse that a downstream ramp generator uses to start moving toward the new level. Both bus lines are resynchronised into a system clock that runs at least eight times the bus clock.

Top module: `svid_rx`

## Requirements
- R1: After reset both rail codes are 7'h7F, both off flags are 1, the power-save permit is 0, and the acknowledge enable and both update pulses are 0.
- R2: A start is a falling data line while the clock line is high. A stop is a rising data line while the clock line is high. Data bits are sampled on rising clock edges, MSB first.
- R3: The address is acknowledged only if address bits 6:4 equal 3'b110. Address bits 3:2 have no effect on acknowledge or on which rail is loaded.
- R4: Address bit 1 selects the core rail and address bit 0 selects the auxiliary rail. With both set, both rails take the same code. With neither set, no acknowledge is driven and nothing changes.
- R5: The acknowledge enable is high from the falling clock edge that ends the eighth bit of a byte until the falling edge that ends the ninth clock. It is released no more than 5 system cycles after that falling edge, and it is never high together with an update pulse.
- R6: Data bit 7 is an active-low power-save flag. On every committed transaction the power-save permit output takes the inverse of that bit.
- R7: Rail codes change only on the cycle after a stop that closes a fully acknowledged transaction. Each rail that changes raises its update pulse for exactly one cycle, and no rail changes without its pulse.
- R8: A rail's off flag is 1 exactly when its committed code lies in 7'h7C..7'h7F. Each rail switches off and on independently of the other.
- R9: A start seen in the middle of a transaction, or before its closing stop, restarts address decoding and discards the partial command. A later stop with no complete command changes nothing.
- R10: A transaction whose eighth address-phase bit (read/write) is 1 is not acknowledged and causes no update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| core_code_o | output | 7 | Committed core rail voltage code |
| aux_code_o | output | 7 | Committed auxiliary rail voltage code |
| core_off_o | output | 1 | Core rail code is in the off range |
| aux_off_o | output | 1 | Auxiliary rail code is in the off range |
| core_upd_o | output | 1 | One-cycle pulse when the core code is loaded |
| aux_upd_o | output | 1 | One-cycle pulse when the auxiliary code is loaded |
| ps_allow_o | output | 1 | Power-saving state permitted |

## Verification
The bound checker watches, on every cycle, that a rail code never moves without its update pulse, that pulses are single-cycle and follow a detected stop, that the off flag agrees with the code loaded beside it, and that acknowledge and commit never overlap. Whether an address is accepted at all (prefix, select bits, direction), which rail receives which code, the meaning of the power-save bit, the exact acknowledge window on the wire, and the discarding of a command cut off by a repeated start depend on whole bus sequences. Only the bench's scenarios show these, by comparing the outputs with values worked out from the requirements.

// File: rtl/svid_pkg.sv
`timescale 1ns/1ps
package svid_pkg;
  localparam int unsigned CODE_W    = 7;
  localparam int unsigned FRAME_W   = 8;
  localparam int unsigned RAIL_N    = 2;
  localparam int unsigned RAIL_AUX  = 0;
  localparam int unsigned RAIL_CORE = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_DATA,
    ST_ACK_D,
    ST_WAIT_STOP,
    ST_SKIP
  } rx_state_e;

  typedef struct packed {
    logic [RAIL_N-1:0] sel;
    logic              ps_n;
    logic [CODE_W-1:0] code;
  } rail_cmd_t;
endpackage

// File: rtl/svid_line_sync.sv
`timescale 1ns/1ps
module svid_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // STAGES flops of synchroniser plus one history flop for edge detect
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/svid_frame_rx.sv
`timescale 1ns/1ps
module svid_frame_rx
  import svid_pkg::*;
#(
  parameter logic [2:0] ADDR_PREFIX = 3'b110
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      scl_rise_i,
  input  logic      scl_fall_i,
  input  logic      sda_i,
  input  logic      start_i,
  input  logic      stop_i,
  output logic      ack_oe_o,
  output logic      cmd_valid_o,
  output rail_cmd_t cmd_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

  rx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [FRAME_W-1:0] data_q, data_d;
  logic [RAIL_N-1:0]  sel_q, sel_d;
  logic               oe_q;
  logic               byte_done, addr_ok;

  assign byte_done = scl_fall_i && (cnt_q == CNT_W'(FRAME_W));
  // sh_q = {addr[6:0], rw}
  assign addr_ok   = (sh_q[FRAME_W-1 -: 3] == ADDR_PREFIX) && !sh_q[0] && (|sh_q[2:1]);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    data_d  = data_q;
    sel_d   = sel_q;
    if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise_i) begin
            sh_d  = {sh_q[FRAME_W-2:0], sda_i};
            cnt_d = CNT_W'(cnt_q + 1'b1);
          end
          if (byte_done) begin
            if (state_q == ST_ADDR) begin
              if (addr_ok) begin
                state_d = ST_ACK_A;
                sel_d   = sh_q[2:1];
              end else begin
                state_d = ST_SKIP;
              end
            end else begin
              state_d = ST_ACK_D;
              data_d  = sh_q;
            end
          end
        end
        ST_ACK_A: if (scl_fall_i) begin
          state_d = ST_DATA;
          cnt_d   = '0;
        end
        ST_ACK_D:     if (scl_fall_i) state_d = ST_WAIT_STOP;
        ST_WAIT_STOP: if (scl_fall_i) state_d = ST_SKIP;  // extra byte: drop
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      sel_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      data_q  <= data_d;
      sel_q   <= sel_d;
      oe_q    <= (state_d == ST_ACK_A) || (state_d == ST_ACK_D);
    end
  end

  assign ack_oe_o    = oe_q;
  assign cmd_valid_o = stop_i && (state_q == ST_WAIT_STOP);
  assign cmd_o.sel   = sel_q;
  assign cmd_o.ps_n  = data_q[FRAME_W-1];
  assign cmd_o.code  = data_q[CODE_W-1:0];
endmodule

// File: rtl/svid_rail_regs.sv
`timescale 1ns/1ps
module svid_rail_regs
  import svid_pkg::*;
#(
  parameter logic [CODE_W-1:0] RESET_CODE = '1,
  parameter logic [CODE_W-1:0] OFF_MIN    = 7'h7C
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cmd_valid_i,
  input  rail_cmd_t                     cmd_i,
  output logic [RAIL_N-1:0][CODE_W-1:0] code_o,
  output logic [RAIL_N-1:0]             off_o,
  output logic [RAIL_N-1:0]             upd_o,
  output logic                          ps_allow_o
);
  localparam logic RESET_OFF = (RESET_CODE >= OFF_MIN);

  for (genvar r = 0; r < RAIL_N; r++) begin : g_rail
    logic [CODE_W-1:0] code_q;
    logic              off_q, upd_q;
    logic              load;

    assign load = cmd_valid_i && cmd_i.sel[r];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q <= RESET_CODE;
        off_q  <= RESET_OFF;
        upd_q  <= 1'b0;
      end else begin
        upd_q <= load;
        if (load) begin
          code_q <= cmd_i.code;
          off_q  <= (cmd_i.code >= OFF_MIN);
        end
      end
    end

    assign code_o[r] = code_q;
    assign off_o[r]  = off_q;
    assign upd_o[r]  = upd_q;
  end

  logic ps_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ps_q <= 1'b0;
    else if (cmd_valid_i) ps_q <= ~cmd_i.ps_n;
  end
  assign ps_allow_o = ps_q;
endmodule

// File: rtl/svid_rx.sv
`timescale 1ns/1ps
module svid_rx
  import svid_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [2:0]        ADDR_PREFIX = 3'b110,
  parameter logic [CODE_W-1:0] RESET_CODE  = 7'h7F,
  parameter logic [CODE_W-1:0] OFF_MIN     = 7'h7C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [CODE_W-1:0] core_code_o,
  output logic [CODE_W-1:0] aux_code_o,
  output logic              core_off_o,
  output logic              aux_off_o,
  output logic              core_upd_o,
  output logic              aux_upd_o,
  output logic              ps_allow_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_det, stop_det;
  logic cmd_valid;
  rail_cmd_t cmd;
  logic [RAIL_N-1:0][CODE_W-1:0] code;
  logic [RAIL_N-1:0] off, upd;

  svid_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i, .rst_ni, .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  svid_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i, .rst_ni, .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  assign start_det = sda_fall && scl_lvl;
  assign stop_det  = sda_rise && scl_lvl;

  svid_frame_rx #(.ADDR_PREFIX(ADDR_PREFIX)) u_frame (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_lvl),
    .start_i(start_det), .stop_i(stop_det),
    .ack_oe_o(sda_oe_o), .cmd_valid_o(cmd_valid), .cmd_o(cmd)
  );

  svid_rail_regs #(.RESET_CODE(RESET_CODE), .OFF_MIN(OFF_MIN)) u_regs (
    .clk_i, .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .code_o(code), .off_o(off), .upd_o(upd), .ps_allow_o(ps_allow_o)
  );

  assign core_code_o = code[RAIL_CORE];
  assign aux_code_o  = code[RAIL_AUX];
  assign core_off_o  = off[RAIL_CORE];
  assign aux_off_o   = off[RAIL_AUX];
  assign core_upd_o  = upd[RAIL_CORE];
  assign aux_upd_o   = upd[RAIL_AUX];
endmodule

// File: rtl/svid_rx_chk.sv
`timescale 1ns/1ps
module svid_rx_chk #(
  parameter logic [6:0] OFF_MIN = 7'h7C
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_oe_o,
  input logic [6:0] core_code_o,
  input logic [6:0] aux_code_o,
  input logic       core_off_o,
  input logic       aux_off_o,
  input logic       core_upd_o,
  input logic       aux_upd_o,
  input logic       stop_seen_i
);
  p_core_moves_with_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(core_code_o) |-> core_upd_o);

  p_aux_moves_with_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(aux_code_o) |-> aux_upd_o);

  p_pulse_after_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_upd_o || aux_upd_o) |-> $past(stop_seen_i));

  p_core_pulse_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_upd_o |=> !core_upd_o);

  p_aux_pulse_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_upd_o |=> !aux_upd_o);

  p_core_off_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_upd_o |-> (core_off_o == (core_code_o >= OFF_MIN)));

  p_aux_off_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_upd_o |-> (aux_off_o == (aux_code_o >= OFF_MIN)));

  p_no_ack_at_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> !(core_upd_o || aux_upd_o));
endmodule

bind svid_rx svid_rx_chk #(.OFF_MIN(OFF_MIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_o(sda_oe_o),
  .core_code_o(core_code_o), .aux_code_o(aux_code_o),
  .core_off_o(core_off_o), .aux_off_o(aux_off_o),
  .core_upd_o(core_upd_o), .aux_upd_o(aux_upd_o),
  .stop_seen_i(stop_det)
);

// File: tb/svid_rx_tb.sv
`timescale 1ns/1ps
module svid_rx_tb;
  localparam int Q   = 8;   // quarter bus period in system cycles
  localparam int NV  = 10;
  // {addr[6:0], rw, data[7:0], ack_a, ack_d, core, aux, ps_allow}
  localparam logic [32:0] VEC [NV] = '{
    {7'b1100010, 1'b0, 8'h10, 1'b1, 1'b1, 7'h10, 7'h7F, 1'b1},
    {7'b1100001, 1'b0, 8'hA0, 1'b1, 1'b1, 7'h10, 7'h20, 1'b0},
    {7'b1100011, 1'b0, 8'h05, 1'b1, 1'b1, 7'h05, 7'h05, 1'b1},
    {7'b1101110, 1'b0, 8'h8A, 1'b1, 1'b1, 7'h0A, 7'h05, 1'b0},
    {7'b1000010, 1'b0, 8'h33, 1'b0, 1'b0, 7'h0A, 7'h05, 1'b0},
    {7'b1100000, 1'b0, 8'h33, 1'b0, 1'b0, 7'h0A, 7'h05, 1'b0},
    {7'b1100010, 1'b1, 8'h33, 1'b0, 1'b0, 7'h0A, 7'h05, 1'b0},
    {7'b1100001, 1'b0, 8'h7C, 1'b1, 1'b1, 7'h0A, 7'h7C, 1'b1},
    {7'b1100010, 1'b0, 8'hFF, 1'b1, 1'b1, 7'h7F, 7'h7C, 1'b0},
    {7'b1100001, 1'b0, 8'h7B, 1'b1, 1'b1, 7'h7F, 7'h7B, 1'b1}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, scl, sda_m, sda_line;
  logic sda_oe, core_off, aux_off, core_upd, aux_upd, ps_allow;
  logic [6:0] core_code, aux_code;
  int checks = 0, fails = 0, core_cnt = 0, aux_cnt = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  svid_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .core_code_o(core_code), .aux_code_o(aux_code),
    .core_off_o(core_off), .aux_off_o(aux_off),
    .core_upd_o(core_upd), .aux_upd_o(aux_upd), .ps_allow_o(ps_allow)
  );

  always @(posedge clk) begin
    if (core_upd) core_cnt <= core_cnt + 1;
    if (aux_upd)  aux_cnt  <= aux_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; wait_cyc(Q);
    sda_m = 1'b0; wait_cyc(Q);
    scl = 1'b0; wait_cyc(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wait_cyc(Q);
    scl = 1'b1; wait_cyc(Q);
    sda_m = 1'b0; wait_cyc(Q);
    scl = 1'b0; wait_cyc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_cyc(Q);
    scl = 1'b1; wait_cyc(Q);
    sda_m = 1'b1; wait_cyc(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_cyc(Q);
    scl = 1'b1; wait_cyc(2*Q);
    scl = 1'b0; wait_cyc(Q);
  endtask

  task automatic ack_slot(input logic exp, input string tag);
    sda_m = 1'b1; wait_cyc(2);
    check({"R5 oe in slot ", tag}, sda_oe, exp);
    wait_cyc(Q-2);
    scl = 1'b1; wait_cyc(Q);
    check({"R3 R4 R10 ack ", tag}, !sda_line, exp);
    wait_cyc(Q-1);
    check({"R5 oe before fall ", tag}, sda_oe, exp);
    wait_cyc(1);
    scl = 1'b0; wait_cyc(5);
    check({"R5 oe release ", tag}, sda_oe, 1'b0);
    wait_cyc(Q-5);
  endtask

  task automatic send_txn(input logic [6:0] a, input logic rw, input logic [7:0] d,
                          input logic exp_a, input logic exp_d,
                          input bit rstart, input bit do_stop);
    if (rstart) bus_rstart(); else bus_start();
    for (int i = 6; i >= 0; i--) put_bit(a[i]);
    put_bit(rw);
    ack_slot(exp_a, "addr");
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    ack_slot(exp_d, "data");
    if (do_stop) bus_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    // R1 reset state
    check("R1 core code", core_code, 7'h7F);
    check("R1 aux code", aux_code, 7'h7F);
    check("R1 core off", core_off, 1'b1);
    check("R1 aux off", aux_off, 1'b1);
    check("R1 ps", ps_allow, 1'b0);
    check("R1 oe", sda_oe, 1'b0);
    check("R1 pulses", {core_upd, aux_upd}, 2'b00);

    // R2 R3 R4 R6 R8 R10: vector walk
    for (int v = 0; v < NV; v++) begin
      logic [32:0] e;
      int c0, a0;
      e  = VEC[v];
      c0 = core_cnt;
      a0 = aux_cnt;
      send_txn(e[32:26], e[25], e[24:17], e[16], e[15], 1'b0, 1'b1);
      wait_cyc(4);
      check("R2 R4 core code", core_code, e[14:8]);
      check("R2 R4 aux code", aux_code, e[7:1]);
      check("R6 ps allow", ps_allow, e[0]);
      check("R8 core off", core_off, e[14:8] >= 7'h7C);
      check("R8 aux off", aux_off, e[7:1] >= 7'h7C);
      check("R7 core pulses", core_cnt - c0, (e[15] & e[27]) ? 1 : 0);
      check("R7 aux pulses", aux_cnt - a0, (e[15] & e[26]) ? 1 : 0);
    end

    // R7: nothing visible before the stop
    begin
      int c0, a0;
      c0 = core_cnt; a0 = aux_cnt;
      send_txn(7'b1100010, 1'b0, 8'h22, 1'b1, 1'b1, 1'b0, 1'b0);
      wait_cyc(2*Q);
      check("R7 core held before stop", core_code, 7'h7F);
      check("R7 no pulse before stop", core_cnt - c0, 0);
      bus_stop();
      wait_cyc(4);
      check("R7 core after stop", core_code, 7'h22);
      check("R7 one core pulse", core_cnt - c0, 1);
      check("R7 aux untouched", aux_cnt - a0, 0);
      check("R8 core on", core_off, 1'b0);
    end

    // R9: repeated start inside the address phase
    begin
      int a0;
      a0 = aux_cnt;
      bus_start();
      put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
      send_txn(7'b1100001, 1'b0, 8'h11, 1'b1, 1'b1, 1'b1, 1'b1);
      wait_cyc(4);
      check("R9 aux after restart", aux_code, 7'h11);
      check("R9 one aux pulse", aux_cnt - a0, 1);
    end

    // R9: complete command cut off by a repeated start, then stop
    begin
      int c0;
      c0 = core_cnt;
      send_txn(7'b1100010, 1'b0, 8'h33, 1'b1, 1'b1, 1'b0, 1'b0);
      bus_rstart();
      bus_stop();
      wait_cyc(4);
      check("R9 core kept", core_code, 7'h22);
      check("R9 no core pulse", core_cnt - c0, 0);
      check("R9 aux kept", aux_code, 7'h11);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule